// File: doc/BRIEF.md
# Ethernet Port DMA Control and Statistics Registers

This block is the software-facing register set of one Ethernet port inside a system controller. A simple 32-bit bus reaches it through byte offsets. On a write (`bus_wr`) the addressed register updates at the clock edge. On a read (`bus_rd`) the register value appears on `bus_rdata` in the same cycle, and any side effect of the read takes place at that edge.

The command register does not store the written word. Each written 1 bit is an action:
- one bit enables receive DMA, and another aborts it;
- each transmit queue (low and high priority) has a start bit and a stop bit.

Reading the command register returns the resulting state. The state also drives the datapath through `rx_dma_en`, `txq_lo_run` and `txq_hi_run`.

The datapath sends in byte-count strobes, frame strobes and interrupt event pulses. Four statistics counters accumulate these strobes and clear themselves when they are read. Event pulses set bits in a cause register, and software clears those bits by writing zeros. A mask register selects which causes raise `irq`. A summary register shows one bit per port of the controller. This port's bit is its own unmasked interrupt state, and the other bits come from the sibling ports.

Top module: `eth_dma_port_regs`

## Requirements
- R1: After reset the command register reads 0x30: both queues stopped, neither active, receive disabled. All four counters read 0, cause and mask read 0, `irq` is 0, and `rx_dma_en`, `txq_lo_run` and `txq_hi_run` are 0.
- R2: The command register is at offset 0x00, and its read bits are: bit0 receive enabled, bit1 always 0, bit2 low queue active, bit3 high queue active, bit4 low queue stopped, bit5 high queue stopped. Writing 1 to bit2 (start low) sets low-active and clears low-stopped. Writing 1 to bit3 (start high) does the same for the high queue. `txq_lo_run` and `txq_hi_run` follow the active bits.
- R3: Writing 1 to bit4 (stop low) clears low-active and sets low-stopped, and bit5 (stop high) does the same for the high queue. When start and stop of the same queue are in one write, stop wins. Bits written 0 change nothing.
- R4: Writing 1 to command bit0 sets receive enable (`rx_dma_en`). Writing 1 to bit1 (abort receive) clears it, and abort wins when both bits are in one write.
- R5: Counters sit at 0x10 (receive bytes), 0x14 (transmit bytes), 0x18 (receive frames) and 0x1C (transmit frames). A byte strobe adds its count input, and a frame strobe adds 1. Sums wrap modulo 2^CNT_W, and reads return the counter zero-extended to 32 bits.
- R6: A read of a counter returns its value and leaves the counter at 0 in the next cycle.
- R7: If a counter's strobe arrives in the same cycle as its read, the read returns the old value and the counter restarts at the strobe's amount.
- R8: The cause register is at 0x20 and is CAUSE_W bits wide. An event pulse sets its bit. A write ANDs the written data into the register, so a 0 clears a bit and a 1 leaves it unchanged. An event pulse in the same cycle as a clearing write leaves its bit set.
- R9: The mask register is at 0x24, and a write replaces it. `irq` is 1 exactly when cause AND mask is nonzero, and it changes in the cycle after a cause or mask update.
- R10: The summary register is at 0x28 and has bit p for port p. Bit PORT_IDX is 1 exactly when cause AND mask is nonzero, and every other bit p mirrors `peer_sum[p]`.
- R11: Reads of any other offset, including unaligned offsets, return 0, and writes to them change no register. When `bus_rd` is 0, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears an addressed counter) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| rx_byte_stb | input | 1 | Add `rx_byte_cnt` to the receive byte counter |
| rx_byte_cnt | input | BCNT_W | Receive byte amount |
| tx_byte_stb | input | 1 | Add `tx_byte_cnt` to the transmit byte counter |
| tx_byte_cnt | input | BCNT_W | Transmit byte amount |
| rx_frame_stb | input | 1 | Count one received frame |
| tx_frame_stb | input | 1 | Count one transmitted frame |
| evt_pulse | input | CAUSE_W | Interrupt event pulses, one per cause bit |
| peer_sum | input | NUM_PORTS | Summary flags of all ports (own bit unused) |
| irq | output | 1 | Interrupt request of this port |
| rx_dma_en | output | 1 | Receive DMA enabled |
| txq_lo_run | output | 1 | Low-priority transmit queue active |
| txq_hi_run | output | 1 | High-priority transmit queue active |

## Verification
The bench builds the block with CNT_W=10 and BCNT_W=8, so a few byte strobes wrap a counter and the modulo behaviour is reachable. CAUSE_W=12 makes the cause and mask registers narrower than the bus, which shows whether upper write bits are dropped. NUM_PORTS=3 with PORT_IDX=1 places this port's summary bit between two sibling bits, so a misplaced or unsubstituted bit shows up in the summary read.

// File: rtl/eth_port_pkg.sv
// Package: shared offsets, command bit positions and types for the
// Ethernet port register block. Assumes byte addressing with word offsets.
package eth_port_pkg;

    // Register byte offsets
    localparam int OFF_CMD   = 'h00;
    localparam int OFF_CNT0  = 'h10;
    localparam int OFF_CAUSE = 'h20;
    localparam int OFF_MASK  = 'h24;
    localparam int OFF_SUM   = 'h28;

    // Counter order inside the counter window (fixed, software relies on it)
    localparam int CNT_RXB = 0;
    localparam int CNT_TXB = 1;
    localparam int CNT_RXF = 2;
    localparam int CNT_TXF = 3;
    localparam int NUM_CNT = 4;

    // Command word bit positions
    localparam int CMD_RXEN     = 0;
    localparam int CMD_ABORT    = 1;
    localparam int CMD_START_LO = 2;
    localparam int CMD_START_HI = 3;
    localparam int CMD_STOP_LO  = 4;
    localparam int CMD_STOP_HI  = 5;
    localparam int CMD_W        = 6;

    // Register select after address decode
    typedef enum logic [3:0] {
        SEL_NONE, SEL_CMD, SEL_CNT, SEL_CAUSE, SEL_MASK, SEL_SUM
    } reg_sel_e;

    // Command register state
    typedef struct packed {
        logic rx_en;
        logic lo_act;
        logic hi_act;
        logic lo_stop;
        logic hi_stop;
    } cmd_state_t;

endpackage

// File: rtl/eth_cmd_reg.sv
// Command register: every written 1 is an action on the queue and receive
// state, not stored data. Within one write, abort beats enable and stop
// beats start. Assumes wr_en is a single-cycle qualified write.
module eth_cmd_reg
    import eth_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CMD_W-1:0]  wdata,
    output cmd_state_t        state
);

    cmd_state_t nxt;

    // Next state from the action bits, later actions overriding earlier ones
    always_comb begin
        nxt = state;
        if (wdata[CMD_RXEN])     nxt.rx_en = 1'b1;
        if (wdata[CMD_ABORT])    nxt.rx_en = 1'b0;
        if (wdata[CMD_START_LO]) begin nxt.lo_act = 1'b1; nxt.lo_stop = 1'b0; end
        if (wdata[CMD_START_HI]) begin nxt.hi_act = 1'b1; nxt.hi_stop = 1'b0; end
        if (wdata[CMD_STOP_LO])  begin nxt.lo_act = 1'b0; nxt.lo_stop = 1'b1; end
        if (wdata[CMD_STOP_HI])  begin nxt.hi_act = 1'b0; nxt.hi_stop = 1'b1; end
    end

    // State register, queues idle and stopped after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '{rx_en: 1'b0, lo_act: 1'b0, hi_act: 1'b0,
                       lo_stop: 1'b1, hi_stop: 1'b1};
        end else if (wr_en) begin
            state <= nxt;
        end
    end

    AST_START_LO_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[CMD_START_LO] && !wdata[CMD_STOP_LO] |=> state.lo_act && !state.lo_stop); // R2
    AST_START_HI_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[CMD_START_HI] && !wdata[CMD_STOP_HI] |=> state.hi_act && !state.hi_stop); // R2
    AST_STOP_LO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[CMD_STOP_LO] |=> state.lo_stop && !state.lo_act); // R3
    AST_STOP_HI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[CMD_STOP_HI] |=> state.hi_stop && !state.hi_act); // R3
    AST_ABORT_RX: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[CMD_ABORT] |=> !state.rx_en); // R4

endmodule

// File: rtl/eth_stat_counter.sv
// Clear-on-read statistics counter. An increment in the clearing cycle
// restarts the count at the increment amount, so no event is dropped.
// Assumes the amount is already sized to the counter width; sums wrap.
module eth_stat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic [W-1:0] amt,
    input  logic         clr,
    output logic [W-1:0] value
);

    // Accumulate, or restart on a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= inc ? amt : '0;
        end else if (inc) begin
            value <= value + amt;
        end
    end

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !inc |=> value == '0); // R6
    AST_CLR_KEEPS_INC: assert property (@(posedge clk) disable iff (!rst_n)
        clr && inc |=> value == $past(amt)); // R7

endmodule

// File: rtl/eth_irq_ctrl.sv
// Interrupt cause and mask. Event pulses set cause bits; a cause write ANDs
// the data in (zero clears), with a simultaneous event taking priority.
// The mask is replaced on write. irq is the OR of the unmasked causes.
module eth_irq_ctrl #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cause_wr,
    input  logic          mask_wr,
    input  logic [CW-1:0] wdata,
    input  logic [CW-1:0] evt,
    output logic [CW-1:0] cause,
    output logic [CW-1:0] mask,
    output logic          irq
);

    // Cause register: write-zero-to-clear, events set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
        end else begin
            cause <= (cause_wr ? (cause & wdata) : cause) | evt;
        end
    end

    // Mask register: plain replace
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (mask_wr) begin
            mask <= wdata;
        end
    end

    // Interrupt request from unmasked causes
    assign irq = |(cause & mask);

    AST_EVT_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        |evt |=> (cause & $past(evt)) == $past(evt)); // R8
    AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_wr |=> (cause & $past(cause)) == $past(cause)); // R8
    AST_MASK_REPLACED: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> mask == $past(wdata)); // R9

endmodule

// File: rtl/eth_dma_port_regs.sv
// Register block for one Ethernet port: command register, four clear-on-read
// statistics counters, interrupt cause/mask and a per-port summary register.
// Assumes one access per cycle, combinational read data in the access cycle,
// and CNT_W <= 32, BCNT_W <= CNT_W, CAUSE_W <= 32, NUM_PORTS <= 32.
module eth_dma_port_regs
    import eth_port_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int CNT_W     = 32,
    parameter int BCNT_W    = 14,
    parameter int CAUSE_W   = 16,
    parameter int NUM_PORTS = 2,
    parameter int PORT_IDX  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 rx_byte_stb,
    input  logic [BCNT_W-1:0]    rx_byte_cnt,
    input  logic                 tx_byte_stb,
    input  logic [BCNT_W-1:0]    tx_byte_cnt,
    input  logic                 rx_frame_stb,
    input  logic                 tx_frame_stb,
    input  logic [CAUSE_W-1:0]   evt_pulse,
    input  logic [NUM_PORTS-1:0] peer_sum,
    output logic                 irq,
    output logic                 rx_dma_en,
    output logic                 txq_lo_run,
    output logic                 txq_hi_run
);

    localparam int CIDX_W = $clog2(NUM_CNT);

    reg_sel_e          sel;
    logic [CIDX_W-1:0] cnt_idx;
    cmd_state_t        cmd_st;
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] mask_q;
    logic              own_sum;
    logic [NUM_PORTS-1:0] sum_bits;

    logic [NUM_CNT-1:0] cnt_inc;
    logic [NUM_CNT-1:0] cnt_clr;
    logic [CNT_W-1:0]   cnt_amt [NUM_CNT];
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];

    // Address decode into a register select and counter index
    always_comb begin
        sel     = SEL_NONE;
        cnt_idx = '0;
        case (bus_addr)
            ADDR_W'(OFF_CMD):              sel = SEL_CMD;
            ADDR_W'(OFF_CNT0 + 4*CNT_RXB): begin sel = SEL_CNT; cnt_idx = CIDX_W'(CNT_RXB); end
            ADDR_W'(OFF_CNT0 + 4*CNT_TXB): begin sel = SEL_CNT; cnt_idx = CIDX_W'(CNT_TXB); end
            ADDR_W'(OFF_CNT0 + 4*CNT_RXF): begin sel = SEL_CNT; cnt_idx = CIDX_W'(CNT_RXF); end
            ADDR_W'(OFF_CNT0 + 4*CNT_TXF): begin sel = SEL_CNT; cnt_idx = CIDX_W'(CNT_TXF); end
            ADDR_W'(OFF_CAUSE):            sel = SEL_CAUSE;
            ADDR_W'(OFF_MASK):             sel = SEL_MASK;
            ADDR_W'(OFF_SUM):              sel = SEL_SUM;
            default:                       sel = SEL_NONE;
        endcase
    end

    eth_cmd_reg u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr && sel == SEL_CMD),
        .wdata (bus_wdata[CMD_W-1:0]),
        .state (cmd_st)
    );

    assign rx_dma_en  = cmd_st.rx_en;
    assign txq_lo_run = cmd_st.lo_act;
    assign txq_hi_run = cmd_st.hi_act;

    // Increment strobes and amounts, in counter-window order
    always_comb begin
        cnt_inc[CNT_RXB] = rx_byte_stb;
        cnt_inc[CNT_TXB] = tx_byte_stb;
        cnt_inc[CNT_RXF] = rx_frame_stb;
        cnt_inc[CNT_TXF] = tx_frame_stb;
        cnt_amt[CNT_RXB] = CNT_W'(rx_byte_cnt);
        cnt_amt[CNT_TXB] = CNT_W'(tx_byte_cnt);
        cnt_amt[CNT_RXF] = CNT_W'(1);
        cnt_amt[CNT_TXF] = CNT_W'(1);
    end

    generate
        for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
            assign cnt_clr[g] = bus_rd && sel == SEL_CNT && cnt_idx == CIDX_W'(g);
            eth_stat_counter #(.W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (cnt_inc[g]),
                .amt   (cnt_amt[g]),
                .clr   (cnt_clr[g]),
                .value (cnt_val[g])
            );
        end
    endgenerate

    eth_irq_ctrl #(.CW(CAUSE_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause_wr (bus_wr && sel == SEL_CAUSE),
        .mask_wr  (bus_wr && sel == SEL_MASK),
        .wdata    (bus_wdata[CAUSE_W-1:0]),
        .evt      (evt_pulse),
        .cause    (cause_q),
        .mask     (mask_q),
        .irq      (own_sum)
    );

    assign irq = own_sum;

    // Summary bits: own port computed here, siblings passed through
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sum
            if (p == PORT_IDX) begin : g_own
                assign sum_bits[p] = own_sum;
            end else begin : g_peer
                assign sum_bits[p] = peer_sum[p];
            end
        end
    endgenerate

    // Read data mux, zero when idle or unmapped
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_CMD:   bus_rdata = {26'd0, cmd_st.hi_stop, cmd_st.lo_stop,
                                        cmd_st.hi_act, cmd_st.lo_act, 1'b0, cmd_st.rx_en};
                SEL_CNT:   bus_rdata = 32'(cnt_val[cnt_idx]);
                SEL_CAUSE: bus_rdata = 32'(cause_q);
                SEL_MASK:  bus_rdata = 32'(mask_q);
                SEL_SUM:   bus_rdata = 32'(sum_bits);
                default:   bus_rdata = '0;
            endcase
        end
    end

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0); // R11

endmodule

// File: tb/tb_eth_dma_port_regs.sv
module tb_eth_dma_port_regs;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W    = 8;
    localparam int CNT_W     = 10;
    localparam int BCNT_W    = 8;
    localparam int CAUSE_W   = 12;
    localparam int NUM_PORTS = 3;
    localparam int PORT_IDX  = 1;

    logic clk = 0;
    logic rst_n = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic rx_byte_stb = 0, tx_byte_stb = 0, rx_frame_stb = 0, tx_frame_stb = 0;
    logic [BCNT_W-1:0] rx_byte_cnt = '0, tx_byte_cnt = '0;
    logic [CAUSE_W-1:0] evt_pulse = '0;
    logic [NUM_PORTS-1:0] peer_sum = '0;
    logic irq, rx_dma_en, txq_lo_run, txq_hi_run;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    int m_rxen, m_lo_act, m_hi_act, m_lo_stop, m_hi_stop;
    int m_cnt [4];
    int m_cause, m_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_dma_port_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BCNT_W(BCNT_W), .CAUSE_W(CAUSE_W),
        .NUM_PORTS(NUM_PORTS), .PORT_IDX(PORT_IDX)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_byte_stb(rx_byte_stb), .rx_byte_cnt(rx_byte_cnt),
        .tx_byte_stb(tx_byte_stb), .tx_byte_cnt(tx_byte_cnt),
        .rx_frame_stb(rx_frame_stb), .tx_frame_stb(tx_frame_stb),
        .evt_pulse(evt_pulse), .peer_sum(peer_sum), .irq(irq),
        .rx_dma_en(rx_dma_en), .txq_lo_run(txq_lo_run), .txq_hi_run(txq_hi_run)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_irq();
        return ((m_cause & m_mask) != 0) ? 1 : 0;
    endfunction

    function automatic logic [31:0] exp_rdata();
        logic [31:0] v = 0;
        if (!bus_rd) return 0;
        case (int'(bus_addr))
            'h00: v = (m_hi_stop << 5) | (m_lo_stop << 4) | (m_hi_act << 3) | (m_lo_act << 2) | m_rxen;
            'h10: v = m_cnt[0];
            'h14: v = m_cnt[1];
            'h18: v = m_cnt[2];
            'h1C: v = m_cnt[3];
            'h20: v = m_cause;
            'h24: v = m_mask;
            'h28: begin
                v = 32'(peer_sum);
                v[PORT_IDX] = exp_irq() != 0;
            end
            default: v = 0;
        endcase
        return v;
    endfunction

    function automatic string auto_tag();
        if (!bus_rd) return "R11";
        case (int'(bus_addr))
            'h00: return "R2";
            'h10, 'h14, 'h18, 'h1C: return "R6";
            'h20: return "R8";
            'h24: return "R9";
            'h28: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Compare outputs for the current inputs, advance the model, next cycle
    task automatic step(input string tag);
        int amt [4];
        logic [3:0] inc;
        int wrap = 1 << CNT_W;
        int cw_mask = (1 << CAUSE_W) - 1;
        #1;
        chk((tag == "") ? auto_tag() : tag, bus_rdata, exp_rdata());
        chk("R9 irq", 32'(irq), 32'(exp_irq()));
        chk("R4 rx_dma_en", 32'(rx_dma_en), 32'(m_rxen));
        chk("R2 txq_lo_run", 32'(txq_lo_run), 32'(m_lo_act));
        chk("R2 txq_hi_run", 32'(txq_hi_run), 32'(m_hi_act));
        inc = {tx_frame_stb, rx_frame_stb, tx_byte_stb, rx_byte_stb};
        amt[0] = int'(rx_byte_cnt); amt[1] = int'(tx_byte_cnt); amt[2] = 1; amt[3] = 1;
        for (int k = 0; k < 4; k++) begin
            if (bus_rd && int'(bus_addr) == 'h10 + 4*k) m_cnt[k] = inc[k] ? amt[k] : 0;
            else if (inc[k]) m_cnt[k] = (m_cnt[k] + amt[k]) % wrap;
        end
        if (bus_wr && bus_addr == 8'h00) begin
            if (bus_wdata[0]) m_rxen = 1;
            if (bus_wdata[1]) m_rxen = 0;
            if (bus_wdata[2]) begin m_lo_act = 1; m_lo_stop = 0; end
            if (bus_wdata[3]) begin m_hi_act = 1; m_hi_stop = 0; end
            if (bus_wdata[4]) begin m_lo_act = 0; m_lo_stop = 1; end
            if (bus_wdata[5]) begin m_hi_act = 0; m_hi_stop = 1; end
        end
        if (bus_wr && bus_addr == 8'h20) m_cause = m_cause & int'(bus_wdata) & cw_mask;
        m_cause = m_cause | int'(evt_pulse);
        if (bus_wr && bus_addr == 8'h24) m_mask = int'(bus_wdata) & cw_mask;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; bus_wdata = 0; bus_addr = 0;
        rx_byte_stb = 0; tx_byte_stb = 0; rx_frame_stb = 0; tx_frame_stb = 0;
        rx_byte_cnt = 0; tx_byte_cnt = 0; evt_pulse = 0;
    endtask

    task automatic rd(input int a, input string tag);
        bus_addr = ADDR_W'(a); bus_rd = 1;
        step(tag);
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string tag);
        bus_addr = ADDR_W'(a); bus_wr = 1; bus_wdata = d;
        step(tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_rxen = 0; m_lo_act = 0; m_hi_act = 0; m_lo_stop = 1; m_hi_stop = 1;
        for (int k = 0; k < 4; k++) m_cnt[k] = 0;
        m_cause = 0; m_mask = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset values
        rd('h00, "R1"); rd('h10, "R1"); rd('h14, "R1"); rd('h18, "R1");
        rd('h1C, "R1"); rd('h20, "R1"); rd('h24, "R1");

        // R2: start each queue
        wr('h00, 32'h04, "R2"); rd('h00, "R2");
        wr('h00, 32'h08, "R2"); rd('h00, "R2");

        // R3: stop, mixed write, stop beats start
        wr('h00, 32'h10, "R3"); rd('h00, "R3");
        wr('h00, 32'h2C, "R3"); rd('h00, "R3");
        wr('h00, 32'h14, "R3"); rd('h00, "R3");
        wr('h00, 32'h00, "R3"); rd('h00, "R3");

        // R4: receive enable and abort
        wr('h00, 32'h01, "R4"); rd('h00, "R4");
        wr('h00, 32'h03, "R4"); rd('h00, "R4");
        wr('h00, 32'h01, "R4"); wr('h00, 32'h02, "R4"); rd('h00, "R4");

        // R5: accumulation and wrap (6 x 200 wraps a 10-bit counter)
        for (int i = 0; i < 6; i++) begin
            rx_byte_stb = 1; rx_byte_cnt = 200; step("R5");
        end
        for (int i = 0; i < 3; i++) begin
            tx_frame_stb = 1; rx_frame_stb = (i != 1); step("R5");
        end
        tx_byte_stb = 1; tx_byte_cnt = 8'hFF; step("R5");
        rd('h10, "R5"); rd('h14, "R5"); rd('h18, "R5"); rd('h1C, "R5");

        // R6: a second read returns zero
        rx_frame_stb = 1; step("R6");
        rd('h18, "R6"); rd('h18, "R6"); rd('h10, "R6");

        // R7: strobe in the read cycle
        tx_byte_stb = 1; tx_byte_cnt = 20; step("R7");
        bus_addr = 8'h14; bus_rd = 1; tx_byte_stb = 1; tx_byte_cnt = 37; step("R7");
        rd('h14, "R7");
        bus_addr = 8'h1C; bus_rd = 1; tx_frame_stb = 1; step("R7");
        rd('h1C, "R7");

        // R8: cause set, write-zero clear, write-one keep, event beats clear
        evt_pulse = 12'h0A5; step("R8");
        rd('h20, "R8");
        wr('h20, 32'hFFFF_FFFB, "R8"); rd('h20, "R8");
        wr('h20, 32'hFFFF_FFFF, "R8"); rd('h20, "R8");
        bus_addr = 8'h20; bus_wr = 1; bus_wdata = 0; evt_pulse = 12'h800; step("R8");
        rd('h20, "R8");

        // R9: mask replace and irq
        wr('h24, 32'hFFFF_F0F0, "R9"); rd('h24, "R9");
        wr('h24, 32'h0000_0800, "R9"); rd('h24, "R9");
        wr('h20, 32'h0, "R9"); rd('h20, "R9");
        evt_pulse = 12'h800; step("R9");
        wr('h24, 32'h0, "R9");

        // R10: summary with peers, own bit both ways
        peer_sum = 3'b101; rd('h28, "R10");
        peer_sum = 3'b010; rd('h28, "R10");
        wr('h24, 32'h800, "R10");
        peer_sum = 3'b000; rd('h28, "R10");
        peer_sum = 3'b111; rd('h28, "R10");

        // R11: unmapped, unaligned, writes ignored, idle read data
        rd('h04, "R11"); rd('h2C, "R11"); rd('h11, "R11"); rd('hFC, "R11");
        wr('h08, 32'hFFFF_FFFF, "R11"); wr('h21, 32'h0, "R11"); wr('h25, 32'h0, "R11");
        rd('h00, "R11"); rd('h20, "R11"); rd('h24, "R11");
        bus_addr = 8'h20; step("R11");

        // Mixed random traffic against the model
        for (int i = 0; i < 600; i++) begin
            int pick = $urandom_range(0, 11);
            int addrs [12] = '{'h00, 'h10, 'h14, 'h18, 'h1C, 'h20, 'h24, 'h28, 'h04, 'h30, 'h13, 'h00};
            bus_addr = ADDR_W'(addrs[pick]);
            case ($urandom_range(0, 3))
                0: bus_rd = 1;
                1: begin bus_wr = 1; bus_wdata = $urandom(); end
                default: ;
            endcase
            rx_byte_stb = $urandom_range(0, 1) == 1; rx_byte_cnt = BCNT_W'($urandom());
            tx_byte_stb = $urandom_range(0, 1) == 1; tx_byte_cnt = BCNT_W'($urandom());
            rx_frame_stb = $urandom_range(0, 1) == 1;
            tx_frame_stb = $urandom_range(0, 1) == 1;
            evt_pulse = ($urandom_range(0, 3) == 0) ? CAUSE_W'($urandom()) : '0;
            peer_sum = NUM_PORTS'($urandom());
            step("");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule